// File: doc/BRIEF.md
# Intra-Task Clock Rate Stepper

This controller picks the clock rate for a single running task. A task starts at the lowest rate and moves up one rate at a time as it runs. The first three slices of its cycle budget run at one quarter, one half and three quarters of full speed. Whatever remains of the budget runs at full speed. The output is a two-bit rate code for an external clock generator, plus a one-cycle completion strobe.

Stepping is allowed only when there is headroom. There must be slack left over from the previous task, and the execution history of this task must show that it finished inside its budget. In every other case the task runs at full speed from its first cycle.

If execution leaves the predicted worst-case path, the controller goes straight to full speed and stays there until the task ends. A task ends when its budget runs out or when the task-complete input is raised, whichever comes first.

Top module: `intra_rate_ctrl`

## Requirements
- R1: The rate code is 2'b00 for quarter rate, 2'b01 for half, 2'b10 for three-quarter and 2'b11 for full.
- R2: On a stepped start with budget B, let S = floor(B*12/100). The first S cycles after the start edge run at quarter rate, the next S at half rate and the next S at three-quarter rate. The rest run at full rate until B cycles have passed.
- R3: While a task runs, the rate code never decreases from one cycle to the next.
- R4: When S is zero, the task runs at full rate from its first cycle.
- R5: When the carried-over slack is zero at start, the whole task runs at full rate.
- R6: When the history value is greater than or equal to the budget, the whole task runs at full rate.
- R7: A deviation flag sampled high during a running task forces full rate from the next cycle until the task ends.
- R8: Exactly B cycles after the start edge, done is high for one cycle. After that the controller is idle with full rate selected.
- R9: A task-complete input sampled high during a running task raises done in the next cycle. This ends the task early.
- R10: A start strobe while a task is running or finishing is ignored. The rate profile of the current task is unchanged.
- R11: While rst_n is low at a clock edge, the controller goes idle with full rate and done low.
- R12: A start with a budget of zero raises done in the next cycle, with full rate selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Task start strobe, accepted when idle |
| budget | input | W | Worst-case cycle budget of the task |
| slack | input | W | Slack carried over from the previous task |
| history | input | W | Recorded execution cycles of this task |
| deviate | input | 1 | Execution left the predicted path |
| task_done | input | 1 | Task finished before its budget |
| rate_sel | output | 2 | Selected clock rate code |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench goes after the boundaries between rate segments. A controller that is off by one there would stretch or shorten a slice and shift every later change by a cycle.

It also covers several cases where a wrong design would produce a visible error:
- Budgets too small for a non-zero slice: a faulty design would sit at a low rate it should skip.
- Zero slack and a history at or above the budget: a design that ignores these would step anyway.
- Deviation and early completion at random points: a design that waits for the next slice would keep a low rate or miss the early strobe.
- A zero budget: a faulty design would count down through zero and hang the task.
- A second start mid-task: a design that accepts it would restart the profile.

// File: rtl/irc_pkg.sv
// Shared types for the intra-task rate stepper.
// Assumes: four rates, ordered from slowest to fastest code.
package irc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QTR,
        ST_HALF,
        ST_TQTR,
        ST_FULL,
        ST_BOOST,
        ST_DONE
    } irc_state_t;

    localparam logic [1:0] RATE_QTR  = 2'b00;
    localparam logic [1:0] RATE_HALF = 2'b01;
    localparam logic [1:0] RATE_TQTR = 2'b10;
    localparam logic [1:0] RATE_FULL = 2'b11;
endpackage

// File: rtl/irc_seg_calc.sv
// Works out the length of one low-rate slice and whether stepping is allowed.
// Assumes: inputs are stable in the start cycle; the result is used only then.
module irc_seg_calc #(
    parameter int W   = 16,
    parameter int PCT = 12
) (
    input  logic [W-1:0] budget,
    input  logic [W-1:0] slack,
    input  logic [W-1:0] history,
    output logic [W-1:0] seg,
    output logic         stepped
);
    localparam int PW = W + 8;

    logic [PW-1:0] scaled;
    logic [PW-1:0] quot;

    // Slice length = floor(budget * PCT / 100); stepping needs slack, headroom and a slice.
    always_comb begin
        scaled  = PW'(budget) * PW'(PCT);
        quot    = scaled / PW'(100);
        seg     = quot[W-1:0];
        stepped = (slack != '0) && (history < budget) && (seg != '0);
    end
endmodule

// File: rtl/irc_counter.sv
// Loadable down counter that flags its last count.
// Assumes: load has priority over decrement; it holds at zero.
module irc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // Count register: reset to zero, load or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/intra_rate_ctrl.sv
// Intra-task rate stepper: quarter, half and three-quarter slices, then full rate.
// Assumes: the start fields are valid in the start cycle; the external clock
// generator follows rate_sel; reset is synchronous and active low.
module intra_rate_ctrl #(
    parameter int W   = 16,
    parameter int PCT = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] budget,
    input  logic [W-1:0] slack,
    input  logic [W-1:0] history,
    input  logic         deviate,
    input  logic         task_done,
    output logic [1:0]   rate_sel,
    output logic         done
);
    import irc_pkg::*;

    irc_state_t   state_q, state_d;
    logic [W-1:0] seg, seg_q;
    logic         stepped;
    logic         rem_load, rem_dec, rem_last;
    logic         seg_load, seg_dec, seg_last;
    logic [W-1:0] seg_val;
    logic         running, idle;

    irc_seg_calc #(.W(W), .PCT(PCT)) u_seg (
        .budget (budget),
        .slack  (slack),
        .history(history),
        .seg    (seg),
        .stepped(stepped)
    );

    irc_counter #(.W(W)) u_rem (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rem_load),
        .load_val(budget),
        .dec     (rem_dec),
        .last    (rem_last)
    );

    assign seg_val = idle ? seg : seg_q;

    irc_counter #(.W(W)) u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seg_load),
        .load_val(seg_val),
        .dec     (seg_dec),
        .last    (seg_last)
    );

    assign idle    = (state_q == ST_IDLE);
    assign running = (state_q == ST_QTR) || (state_q == ST_HALF) || (state_q == ST_TQTR) ||
                     (state_q == ST_FULL) || (state_q == ST_BOOST);

    // Next-state and counter control.
    always_comb begin
        state_d  = state_q;
        rem_load = 1'b0;
        rem_dec  = 1'b0;
        seg_load = 1'b0;
        seg_dec  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    rem_load = 1'b1;
                    seg_load = 1'b1;
                    if (budget == '0)
                        state_d = ST_DONE;
                    else if (stepped)
                        state_d = ST_QTR;
                    else
                        state_d = ST_FULL;
                end
            end
            ST_QTR, ST_HALF, ST_TQTR: begin
                rem_dec = 1'b1;
                seg_dec = 1'b1;
                if (rem_last || task_done)
                    state_d = ST_DONE;
                else if (deviate)
                    state_d = ST_BOOST;
                else if (seg_last) begin
                    seg_load = 1'b1;
                    case (state_q)
                        ST_QTR:  state_d = ST_HALF;
                        ST_HALF: state_d = ST_TQTR;
                        default: state_d = ST_FULL;
                    endcase
                end
            end
            ST_FULL, ST_BOOST: begin
                rem_dec = 1'b1;
                if (rem_last || task_done)
                    state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and slice length latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (idle && start)
                seg_q <= seg;
        end
    end

    // Rate code decoded from the registered state.
    always_comb begin
        case (state_q)
            ST_QTR:  rate_sel = RATE_QTR;
            ST_HALF: rate_sel = RATE_HALF;
            ST_TQTR: rate_sel = RATE_TQTR;
            default: rate_sel = RATE_FULL;
        endcase
    end

    assign done = (state_q == ST_DONE);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_rate_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (rate_sel >= $past(rate_sel)));

    assert_boost_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && deviate) |=> (rate_sel == RATE_FULL));

    assert_no_slack_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && slack == '0) |=> (rate_sel == RATE_FULL));

    assert_zero_budget_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && budget == '0) |=> done);

    assert_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && task_done) |=> done);
endmodule

// File: tb/intra_rate_ctrl_test.sv
module intra_rate_ctrl_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] budget = '0;
    logic [W-1:0] slack = '0;
    logic [W-1:0] history = '0;
    logic         deviate = 1'b0;
    logic         task_done = 1'b0;
    logic [1:0]   rate_sel;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    intra_rate_ctrl #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .budget(budget),
        .slack(slack), .history(history), .deviate(deviate),
        .task_done(task_done), .rate_sel(rate_sel), .done(done)
    );

    function automatic int exp_seg(int b);
        return (b * 12) / 100;
    endfunction

    // Expected rate t cycles after the start edge, for a task still running.
    function automatic logic [1:0] exp_rate(int t, int s, bit stepped, int dev_at);
        if (dev_at >= 0 && t > dev_at) return 2'b11;
        if (!stepped) return 2'b11;
        if (t < s) return 2'b00;
        if (t < 2 * s) return 2'b01;
        if (t < 3 * s) return 2'b10;
        return 2'b11;
    endfunction

    task automatic check(string tag, logic [1:0] r_exp, logic d_exp);
        checks++;
        if (rate_sel !== r_exp || done !== d_exp) begin
            errors++;
            $display("FAIL %s: rate=%b done=%b expected rate=%b done=%b",
                     tag, rate_sel, done, r_exp, d_exp);
        end
    endtask

    // Runs one task; -1 disables the deviation, early end and restart events.
    task automatic run_task(string tag, int b, int sl, int hi,
                            int dev_at, int fin_at, int restart_at);
        int  s       = exp_seg(b);
        bit  stepped = (sl != 0) && (hi < b) && (s != 0);
        int  fin     = b;
        string t_tag;
        if (fin_at >= 0 && fin_at + 1 < fin) fin = fin_at + 1;
        budget  = W'(b);
        slack   = W'(sl);
        history = W'(hi);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= fin + 1; t++) begin
            if (t < fin) begin
                t_tag = (dev_at >= 0 && t > dev_at) ? "R7" : tag;
                check(t_tag, exp_rate(t, s, stepped, dev_at), 1'b0);
            end else if (t == fin) begin
                t_tag = (b == 0) ? "R12" : ((fin < b) ? "R9" : "R8");
                check(t_tag, 2'b11, 1'b1);
            end else begin
                check("R8", 2'b11, 1'b0);
            end
            deviate   = (t == dev_at);
            task_done = (t == fin_at);
            start     = (t == restart_at);
            if (t == restart_at) begin
                budget = W'(b + 37);
                slack  = W'(5);
                history = '0;
            end
            @(negedge clk);
        end
        deviate   = 1'b0;
        task_done = 1'b0;
        start     = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R11", 2'b11, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 2'b11, 1'b0);

        run_task("R2", 100, 10, 50, -1, -1, -1);   // S=12, codes per R1
        run_task("R1", 250, 3, 0, -1, -1, -1);     // S=30
        run_task("R4", 8, 4, 1, -1, -1, -1);       // S=0
        run_task("R5", 100, 0, 10, -1, -1, -1);
        run_task("R6", 100, 7, 100, -1, -1, -1);
        run_task("R6", 100, 7, 99, -1, -1, -1);
        run_task("R7", 200, 9, 20, 30, -1, -1);
        run_task("R7", 100, 9, 20, 3, -1, -1);
        run_task("R9", 150, 9, 20, -1, 20, -1);
        run_task("R10", 120, 9, 20, -1, -1, 5);
        run_task("R10", 60, 9, 20, -1, -1, 59);
        run_task("R12", 0, 9, 0, -1, -1, -1);
        run_task("R4", 1, 9, 0, -1, -1, -1);

        // Mid-task reset returns to idle at full rate.
        budget = W'(100); slack = W'(4); history = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", 2'b11, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 2'b11, 1'b0);

        for (int i = 0; i < 40; i++) begin
            int b  = int'($urandom_range(0, 400));
            int sl = int'($urandom_range(0, 4));
            int hi = int'($urandom_range(0, 500));
            int dv = -1;
            int fn = -1;
            if (b > 2 && $urandom_range(0, 3) == 0) dv = int'($urandom_range(0, b - 2));
            if (b > 2 && $urandom_range(0, 3) == 0) fn = int'($urandom_range(0, b - 2));
            run_task("R2", b, sl, hi, dv, fn, -1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule